// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Converter Code Register

This block is the digital front end of a 16-bit converter that sits on an 8-bit processor bus. The processor sends a word in two byte cycles. The same eight data lines carry the upper half in one cycle and the lower half in the other, and each half goes into its own input latch. A separate transfer strobe then copies both latches into the output register that drives the converter code. Because there are two stages, software can stage a new word while the converter keeps its present code, and the code changes only when the transfer happens.

A write with the byte-select line high loads the upper latch, and the lower latch follows the bus at the same time. The usual sequence is therefore a high-byte write, then a low-byte write that overwrites the lower half. The transfer may be merged with that low-byte write. In automatic-transfer wiring, transfer is tied to chip select and write-2 is tied to write-1, so every write also transfers. A system clock samples all strobes and data. The latches behave as transparent latches in the clocked domain: they follow the bus in every sampled cycle in which they are enabled, and they hold once the enable goes away.

A timing checker measures set-up, hold and pulse widths in clock cycles. The first violation it sees sets a sticky flag and a cause code.

Top module: `dbuf_dac_loader`

## Requirements
- R1: While `rst` is high, the cycle after it clears `code_out`, both input latches, `viol_flag` and `viol_cause` to zero.
- R2: A write (`cs_n`=0 and `wr1_n`=0 sampled) with `hi_sel`=1 loads the bus into both the upper and the lower latch. A following transfer then gives `code_out` = {bus, bus}.
- R3: A write with `hi_sel`=0 loads only the lower latch, and the upper latch keeps its value. Transfer word = {upper latch, lower latch}, with the upper latch in bits 15..8.
- R4: `wr1_n` low while `cs_n` is high changes neither latch, and a later transfer shows the previous word.
- R5: `code_out` changes only in cycles with an active transfer. Latch writes with no transfer leave it unchanged.
- R6: A transfer happens only while `wr2_n` and `xfer_n` are both low. Either one low on its own changes nothing.
- R7: When a low-byte write and a transfer are active together, `code_out` takes the new word, including that cycle's bus value, two clock edges after the inputs are applied.
- R8: In automatic-transfer wiring (`xfer_n` follows `cs_n`, `wr2_n` follows `wr1_n`), a high-byte write of H produces {H,H}, and a following low-byte write of L produces {H,L}.
- R9: While a latch stays enabled it follows every bus change. The value sampled in the last enabled cycle is kept.
- R10: Set-up and hold cause codes:
  - 1: `cs_n` or `hi_sel` changed fewer than T_CS_SU cycles before a write starts.
  - 2: `cs_n` or `hi_sel` changed fewer than T_CS_HD cycles after a write ends.
  - 3: the bus changed fewer than T_D_SU cycles before a write ends.
  - 4: the bus changed fewer than T_D_HD cycles after a write ends.
- R11: Pulse-width cause codes: a write pulse shorter than T_PW cycles gives code 5, and a transfer pulse (`wr2_n` and `xfer_n` both low) shorter than T_PW cycles gives code 6.
- R12: The first violation sets `viol_flag` and latches its code. When several violations occur in the same cycle, the lowest code wins. Later violations change nothing until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and data |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Byte data bus |
| cs_n | input | 1 | Chip select, active low, gates write-1 |
| wr1_n | input | 1 | Latch write strobe, active low |
| wr2_n | input | 1 | Transfer gate, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| hi_sel | input | 1 | 1 = high-byte write (both latches), 0 = low byte only |
| code_out | output | 16 | Output register value, the converter code |
| viol_flag | output | 1 | Sticky timing-violation flag |
| viol_cause | output | 3 | Code of the first violation, 0 = none |

## Verification
The assertions check four behaviours on every cycle: the output code holds in every cycle without a transfer, the upper latch holds unless a high-byte write is active, the lower latch holds unless a qualified write is active, and the flag and cause stay frozen once the flag is set. Reset clearing the code is also checked each cycle. Only the bench scenarios can show the values that land in the registers: the duplicated upper byte, the merged and automatic transfers, transparency during a held strobe, and the exact cause code each malformed sequence produces. The bench also covers the priority and stickiness of the first cause.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef struct packed {
    logic cs_n;
    logic wr1_n;
    logic wr2_n;
    logic xfer_n;
    logic hi_sel;
  } strobes_t;

  localparam strobes_t STB_IDLE = '{cs_n: 1'b1, wr1_n: 1'b1, wr2_n: 1'b1,
                                    xfer_n: 1'b1, hi_sel: 1'b0};

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_CTL_SU  = 3'd1,
    CAUSE_CTL_HD  = 3'd2,
    CAUSE_DAT_SU  = 3'd3,
    CAUSE_DAT_HD  = 3'd4,
    CAUSE_WR_PW   = 3'd5,
    CAUSE_XF_PW   = 3'd6
  } cause_e;
endpackage

// File: rtl/dbr_sampler.sv
module dbr_sampler
  import dbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  strobes_t      stb_in,
  input  logic [DW-1:0] bus_in,
  output strobes_t      s_stb,
  output logic [DW-1:0] s_bus,
  output strobes_t      p_stb,
  output logic [DW-1:0] p_bus
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_stb <= STB_IDLE;
      p_stb <= STB_IDLE;
      s_bus <= '0;
      p_bus <= '0;
    end else begin
      s_stb <= stb_in;
      s_bus <= bus_in;
      p_stb <= s_stb;
      p_bus <= s_bus;
    end
  end
endmodule

// File: rtl/dbr_in_latches.sv
module dbr_in_latches #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_act,
  input  logic          hi_sel,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] hi_nxt,
  output logic [DW-1:0] lo_nxt,
  output logic [DW-1:0] hi_q,
  output logic [DW-1:0] lo_q
);
  always_comb begin
    hi_nxt = (wr_act && hi_sel) ? bus : hi_q;
    lo_nxt = wr_act ? bus : lo_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  assert_hi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_act && hi_sel) |=> $stable(hi_q));

  assert_lo_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_act |=> $stable(lo_q));
endmodule

// File: rtl/dbr_out_reg.sv
module dbr_out_reg #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_act,
  input  logic [WW-1:0] word_nxt,
  output logic [WW-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst)           code_q <= '0;
    else if (xfer_act) code_q <= word_nxt;
  end

  assert_code_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !xfer_act |=> $stable(code_q));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (code_q == '0));
endmodule

// File: rtl/dbr_timing_chk.sv
module dbr_timing_chk
  import dbr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int T_CS_SU = 19,
  parameter int T_CS_HD = 2,
  parameter int T_D_SU  = 9,
  parameter int T_D_HD  = 9,
  parameter int T_PW    = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  strobes_t      s_stb,
  input  strobes_t      p_stb,
  input  logic [DW-1:0] s_bus,
  input  logic [DW-1:0] p_bus,
  output logic          viol_flag,
  output logic [2:0]    viol_cause
);
  localparam int TM1  = (T_CS_SU > T_CS_HD) ? T_CS_SU : T_CS_HD;
  localparam int TM2  = (T_D_SU > T_D_HD) ? T_D_SU : T_D_HD;
  localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX = (TM3 > T_PW) ? TM3 : T_PW;
  localparam int CW   = $clog2(TMAX + 2);
  localparam logic [CW-1:0] CMAX  = CW'(TMAX + 1);
  localparam logic [CW-1:0] L_CSU = CW'(T_CS_SU);
  localparam logic [CW-1:0] L_CHD = CW'(T_CS_HD);
  localparam logic [CW-1:0] L_DSU = CW'(T_D_SU);
  localparam logic [CW-1:0] L_DHD = CW'(T_D_HD);
  localparam logic [CW-1:0] L_PW  = CW'(T_PW);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v >= CMAX) ? CMAX : v + 1'b1;
  endfunction

  logic wr_s, wr_p, xf_s, xf_p, wr_start, wr_end, xf_end, ctl_chg, dat_chg;
  logic [CW-1:0] ctl_age_q, dat_age_q, end_age_q, wlen_q, xlen_q;
  logic [CW-1:0] ctl_age_now, dat_age_now, end_age_now;
  cause_e cause_now;

  always_comb begin
    wr_s     = !s_stb.cs_n && !s_stb.wr1_n;
    wr_p     = !p_stb.cs_n && !p_stb.wr1_n;
    xf_s     = !s_stb.wr2_n && !s_stb.xfer_n;
    xf_p     = !p_stb.wr2_n && !p_stb.xfer_n;
    wr_start = wr_s && !wr_p;
    wr_end   = !wr_s && wr_p;
    xf_end   = !xf_s && xf_p;
    ctl_chg  = (s_stb.cs_n != p_stb.cs_n) || (s_stb.hi_sel != p_stb.hi_sel);
    dat_chg  = (s_bus != p_bus);
    ctl_age_now = ctl_chg ? '0 : sat_inc(ctl_age_q);
    dat_age_now = dat_chg ? '0 : sat_inc(dat_age_q);
    end_age_now = wr_end  ? '0 : sat_inc(end_age_q);
  end

  always_comb begin
    if (wr_start && ctl_age_now < L_CSU)      cause_now = CAUSE_CTL_SU;
    else if (ctl_chg && end_age_now < L_CHD)  cause_now = CAUSE_CTL_HD;
    else if (wr_end && dat_age_now < L_DSU)   cause_now = CAUSE_DAT_SU;
    else if (dat_chg && end_age_now < L_DHD)  cause_now = CAUSE_DAT_HD;
    else if (wr_end && wlen_q < L_PW)         cause_now = CAUSE_WR_PW;
    else if (xf_end && xlen_q < L_PW)         cause_now = CAUSE_XF_PW;
    else                                      cause_now = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_age_q  <= CMAX;
      dat_age_q  <= CMAX;
      end_age_q  <= CMAX;
      wlen_q     <= '0;
      xlen_q     <= '0;
      viol_flag  <= 1'b0;
      viol_cause <= CAUSE_NONE;
    end else begin
      ctl_age_q <= ctl_age_now;
      dat_age_q <= dat_age_now;
      end_age_q <= end_age_now;
      if (wr_s) wlen_q <= wr_p ? sat_inc(wlen_q) : CW'(1);
      if (xf_s) xlen_q <= xf_p ? sat_inc(xlen_q) : CW'(1);
      if (!viol_flag && cause_now != CAUSE_NONE) begin
        viol_flag  <= 1'b1;
        viol_cause <= cause_now;
      end
    end
  end

  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    viol_flag |=> (viol_flag && $stable(viol_cause)));
endmodule

// File: rtl/dbuf_dac_loader.sv
module dbuf_dac_loader
  import dbr_pkg::*;
#(
  parameter int DW      = 8,
  parameter int T_CS_SU = 19,
  parameter int T_CS_HD = 2,
  parameter int T_D_SU  = 9,
  parameter int T_D_HD  = 9,
  parameter int T_PW    = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   bus_in,
  input  logic            cs_n,
  input  logic            wr1_n,
  input  logic            wr2_n,
  input  logic            xfer_n,
  input  logic            hi_sel,
  output logic [2*DW-1:0] code_out,
  output logic            viol_flag,
  output logic [2:0]      viol_cause
);
  localparam int WW = 2 * DW;

  strobes_t      stb_in, s_stb, p_stb;
  logic [DW-1:0] s_bus, p_bus, hi_nxt, lo_nxt, hi_q, lo_q;
  logic          wr_act, xfer_act;

  assign stb_in   = '{cs_n: cs_n, wr1_n: wr1_n, wr2_n: wr2_n,
                      xfer_n: xfer_n, hi_sel: hi_sel};
  assign wr_act   = !s_stb.cs_n && !s_stb.wr1_n;
  assign xfer_act = !s_stb.wr2_n && !s_stb.xfer_n;

  dbr_sampler #(.DW(DW)) u_smp (
    .clk(clk), .rst(rst), .stb_in(stb_in), .bus_in(bus_in),
    .s_stb(s_stb), .s_bus(s_bus), .p_stb(p_stb), .p_bus(p_bus));

  dbr_in_latches #(.DW(DW)) u_lat (
    .clk(clk), .rst(rst), .wr_act(wr_act), .hi_sel(s_stb.hi_sel),
    .bus(s_bus), .hi_nxt(hi_nxt), .lo_nxt(lo_nxt), .hi_q(hi_q), .lo_q(lo_q));

  dbr_out_reg #(.WW(WW)) u_out (
    .clk(clk), .rst(rst), .xfer_act(xfer_act),
    .word_nxt({hi_nxt, lo_nxt}), .code_q(code_out));

  dbr_timing_chk #(.DW(DW), .T_CS_SU(T_CS_SU), .T_CS_HD(T_CS_HD),
                   .T_D_SU(T_D_SU), .T_D_HD(T_D_HD), .T_PW(T_PW)) u_chk (
    .clk(clk), .rst(rst), .s_stb(s_stb), .p_stb(p_stb),
    .s_bus(s_bus), .p_bus(p_bus),
    .viol_flag(viol_flag), .viol_cause(viol_cause));
endmodule

// File: tb/dbuf_dac_loader_tb_top.sv
module dbuf_dac_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_in = '0;
  logic cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1, hi_sel = 1'b0;
  logic [15:0] code_out;
  logic viol_flag;
  logic [2:0] viol_cause;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] hm = '0, lm = '0;
  logic [15:0] cm = '0, last_code = '0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  dbuf_dac_loader #(.DW(8), .T_CS_SU(4), .T_CS_HD(2), .T_D_SU(3),
                    .T_D_HD(3), .T_PW(4)) dut_i (
    .clk(clk), .rst(rst), .bus_in(bus_in), .cs_n(cs_n), .wr1_n(wr1_n),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .hi_sel(hi_sel), .code_out(code_out),
    .viol_flag(viol_flag), .viol_cause(viol_cause));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops expected words as code_out changes
  always @(negedge clk) begin
    if (code_out !== last_code) begin
      if (!rst) begin
        if (exp_q.size() == 0)
          chk(0, "R5 unexpected code change", code_out, last_code);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(code_out === e, "R6 scoreboard word", code_out, e);
        end
      end
      last_code = code_out;
    end
  end

  // driver: set pins, update model, hold n cycles
  task automatic drv(input logic c, input logic w1, input logic w2,
                     input logic x, input logic h, input logic [7:0] b,
                     input int n);
    logic [15:0] prev;
    cs_n = c; wr1_n = w1; wr2_n = w2; xfer_n = x; hi_sel = h; bus_in = b;
    prev = cm;
    if (!c && !w1) begin
      if (h) hm = b;
      lm = b;
    end
    if (!w2 && !x) cm = {hm, lm};
    if (cm != prev) exp_q.push_back(cm);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic h, input logic [7:0] b, input bit merge,
                         input bit auto_x);
    logic xa;
    xa = merge ? 1'b0 : 1'b1;
    if (auto_x) begin
      drv(0, 1, 1, 0, h, b, 5);
      drv(0, 0, 0, 0, h, b, 5);
      drv(0, 1, 1, 0, h, b, 5);
      drv(1, 1, 1, 1, h, b, 5);
    end else begin
      drv(0, 1, 1, 1, h, b, 5);
      drv(0, 0, xa, xa, h, b, 5);
      drv(0, 1, 1, 1, h, b, 5);
      drv(1, 1, 1, 1, h, b, 5);
    end
  endtask

  task automatic xfer_only();
    drv(1, 1, 1, 0, hi_sel, bus_in, 3);
    drv(1, 1, 0, 0, hi_sel, bus_in, 5);
    drv(1, 1, 1, 0, hi_sel, bus_in, 3);
    drv(1, 1, 1, 1, hi_sel, bus_in, 3);
  endtask

  task automatic do_reset();
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1; hi_sel = 0; bus_in = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    hm = '0; lm = '0; cm = '0;
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_code(input string tag);
    chk(code_out === cm, tag, code_out, cm);
  endtask

  task automatic check_viol(input logic f, input logic [2:0] c,
                            input string tag);
    chk(viol_flag === f && viol_cause === c, tag, {viol_flag, viol_cause},
        {f, c});
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    @(negedge clk);
    // force nonzero state, then reset
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    wr_byte(1, 8'h5A, 0, 0);
    xfer_only();
    rst = 1;
    @(negedge clk); @(negedge clk);
    chk(code_out === 16'h0 && viol_flag === 0 && viol_cause === 0,
        "R1 reset clear", {code_out, viol_flag, viol_cause}, 0);
    rst = 0; hm = '0; lm = '0; cm = '0; exp_q.delete();
    repeat (2) @(negedge clk);
    xfer_only();
    check_code("R1 latches cleared by reset");

    // R2 high-byte write fills both latches; R5 output holds until transfer
    wr_byte(1, 8'hC3, 0, 0);
    chk(code_out === 16'h0, "R5 no transfer, code holds", code_out, 0);
    xfer_only();
    check_code("R2 high write duplicates");
    chk(code_out === 16'hC3C3, "R2 value", code_out, 16'hC3C3);

    // R3 low-byte write only
    wr_byte(0, 8'h17, 0, 0);
    chk(code_out === 16'hC3C3, "R5 held after low write", code_out, 16'hC3C3);
    xfer_only();
    chk(code_out === 16'hC317, "R3 low write", code_out, 16'hC317);

    // R4 write without chip select ignored
    drv(1, 1, 1, 1, 1, 8'hEE, 3);
    drv(1, 0, 1, 1, 1, 8'hEE, 5);
    drv(1, 1, 1, 1, 1, 8'hEE, 5);
    xfer_only();
    chk(code_out === 16'hC317, "R4 cs high ignored", code_out, 16'hC317);

    // R6 half transfer strobes do nothing
    wr_byte(1, 8'h42, 0, 0);
    drv(1, 1, 0, 1, 0, 8'h42, 6);
    drv(1, 1, 1, 1, 0, 8'h42, 3);
    drv(1, 1, 1, 0, 0, 8'h42, 6);
    drv(1, 1, 1, 1, 0, 8'h42, 3);
    chk(code_out === 16'hC317, "R6 single strobe no transfer", code_out,
        16'hC317);
    xfer_only();
    chk(code_out === 16'h4242, "R6 full transfer", code_out, 16'h4242);

    // R7 merged low write and transfer
    wr_byte(1, 8'h9D, 0, 0);
    wr_byte(0, 8'h61, 1, 0);
    chk(code_out === 16'h9D61, "R7 merged transfer", code_out, 16'h9D61);

    // R7 latency: two edges after pins
    wr_byte(1, 8'h3C, 0, 0);
    drv(0, 1, 1, 1, 0, 8'hA5, 5);
    drv(0, 0, 0, 0, 0, 8'hA5, 1);
    chk(code_out === 16'h9D61, "R7 not yet after one edge", code_out, 16'h9D61);
    @(negedge clk);
    chk(code_out === 16'h3CA5, "R7 updated after two edges", code_out,
        16'h3CA5);
    repeat (3) @(negedge clk);
    drv(0, 1, 1, 1, 0, 8'hA5, 5);
    drv(1, 1, 1, 1, 0, 8'hA5, 5);

    // R8 automatic transfer
    wr_byte(1, 8'h7E, 0, 1);
    chk(code_out === 16'h7E7E, "R8 auto high", code_out, 16'h7E7E);
    wr_byte(0, 8'h08, 0, 1);
    chk(code_out === 16'h7E08, "R8 auto low", code_out, 16'h7E08);

    // R9 transparency while enable held
    drv(0, 1, 1, 1, 0, 8'h11, 5);
    drv(0, 0, 0, 0, 0, 8'h11, 2);
    drv(0, 0, 0, 0, 0, 8'hB4, 4);
    drv(0, 1, 1, 1, 0, 8'hB4, 5);
    drv(1, 1, 1, 1, 0, 8'hB4, 5);
    chk(code_out === 16'h7EB4, "R9 last value kept", code_out, 16'h7EB4);
    check_viol(0, 3'd0, "R10 clean protocol no flag");

    // R11 short write, then R12 sticky
    do_reset();
    drv(0, 1, 1, 1, 0, 8'h21, 5);
    drv(0, 0, 1, 1, 0, 8'h21, 2);
    drv(0, 1, 1, 1, 0, 8'h21, 5);
    drv(1, 1, 1, 1, 0, 8'h21, 5);
    check_viol(1, 3'd5, "R11 short write code 5");
    drv(1, 1, 1, 1, 0, 8'h21, 5);
    drv(0, 0, 1, 1, 0, 8'h21, 5);
    drv(0, 1, 1, 1, 0, 8'h21, 5);
    drv(1, 1, 1, 1, 0, 8'h21, 5);
    check_viol(1, 3'd5, "R12 first cause kept");
    do_reset();
    check_viol(0, 3'd0, "R12 reset clears flag");

    // R10 cause 1
    drv(1, 1, 1, 1, 0, 8'h33, 5);
    drv(0, 0, 1, 1, 0, 8'h33, 5);
    drv(0, 1, 1, 1, 0, 8'h33, 5);
    drv(1, 1, 1, 1, 0, 8'h33, 5);
    check_viol(1, 3'd1, "R10 ctl setup code 1");
    do_reset();
    // R10 cause 2
    drv(0, 1, 1, 1, 0, 8'h33, 5);
    drv(0, 0, 1, 1, 0, 8'h33, 5);
    drv(0, 1, 1, 1, 0, 8'h33, 1);
    drv(1, 1, 1, 1, 0, 8'h33, 5);
    check_viol(1, 3'd2, "R10 ctl hold code 2");
    do_reset();
    // R10 cause 3
    drv(0, 1, 1, 1, 0, 8'h33, 5);
    drv(0, 0, 1, 1, 0, 8'h33, 4);
    drv(0, 0, 1, 1, 0, 8'h44, 1);
    drv(0, 1, 1, 1, 0, 8'h44, 5);
    drv(1, 1, 1, 1, 0, 8'h44, 5);
    check_viol(1, 3'd3, "R10 data setup code 3");
    do_reset();
    // R10 cause 4
    drv(0, 1, 1, 1, 0, 8'h33, 5);
    drv(0, 0, 1, 1, 0, 8'h33, 5);
    drv(0, 1, 1, 1, 0, 8'h33, 1);
    drv(0, 1, 1, 1, 0, 8'h55, 5);
    drv(1, 1, 1, 1, 0, 8'h55, 5);
    check_viol(1, 3'd4, "R10 data hold code 4");
    do_reset();
    // R11 cause 6
    drv(1, 1, 0, 1, 0, 8'h00, 3);
    drv(1, 1, 0, 0, 0, 8'h00, 2);
    drv(1, 1, 0, 1, 0, 8'h00, 3);
    drv(1, 1, 1, 1, 0, 8'h00, 3);
    check_viol(1, 3'd6, "R11 short transfer code 6");
    // R12 same-cycle priority: short write whose cs rises with wr1 -> 2 beats 5
    do_reset();
    drv(0, 1, 1, 1, 0, 8'h00, 5);
    drv(0, 0, 1, 1, 0, 8'h00, 2);
    drv(1, 1, 1, 1, 0, 8'h00, 5);
    check_viol(1, 3'd2, "R12 lowest code wins");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard empty at end", exp_q.size(), 0);
    finish_run();
  end
endmodule